// File: doc/BRIEF.md
# Watermark-Driven DMA Burst Requester with TX/RX FIFOs

This block sits between a serial shift engine and a general-purpose DMA engine. It holds two FIFOs of equal depth (32 entries by default). The transmit FIFO is filled by the DMA side and drained by the serial engine. The receive FIFO is filled by the serial engine and drained by the DMA side.

Each FIFO has a programmable watermark that decides when to ask the DMA engine for a burst. The transmit side asks for more data once its fill level has dropped to its watermark or below. The receive side asks to be emptied once its fill level is at least one above its watermark. A raised request stays up until the DMA side has moved a programmable burst of items. The request is then dropped for one cycle and checked again against the fill level.

A typical setting puts the transmit watermark at the depth minus the burst size, and the receive watermark at the burst size minus one. With these values, each burst exactly fits the room or the data that is available.

Top module: `wm_dma_fifos`

## Requirements
- R1: During and right after reset, both fill levels are 0, both requests are low and both error flags are low.
- R2: Words written by the DMA side into the transmit FIFO come out on the engine read data in the order they were written. The read data always shows the oldest stored word.
- R3: Words written by the engine into the receive FIFO come out on the DMA read data in the order they were written.
- R4: An accepted write adds one to a FIFO's level and an accepted read subtracts one. An accepted write and an accepted read in the same cycle leave the level unchanged. A level never exceeds DEPTH.
- R5: While the transmit request is low, it goes high at the next clock edge if the transmit level is less than or equal to the transmit watermark. Otherwise it stays low, including when the level is exactly one above the watermark.
- R6: Once a request is high, it stays high whatever the fill level does, until the burst is complete.
- R7: A burst is complete at the accepted DMA transfer that brings the count of accepted DMA transfers since the request rose to the burst size. A burst size of 0 counts as 1. At that edge the request falls, and at the following edge it is evaluated afresh from the level.
- R8: A write to a full FIFO or a read from an empty FIFO leaves the FIFO contents and level untouched. It sets that FIFO's error flag, which then stays high until reset.
- R9: While the receive request is low, it goes high at the next clock edge if the receive level is at least the receive watermark plus one. It stays low when the level equals the watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_tx_wm | input | LW | Transmit watermark |
| cfg_rx_wm | input | LW | Receive watermark |
| cfg_burst | input | LW | Items per DMA burst |
| dma_tx_push | input | 1 | DMA writes a word into the transmit FIFO |
| dma_tx_wdata | input | WIDTH | Word written by DMA |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_rdata | output | WIDTH | Oldest transmit word |
| tx_level | output | LW | Transmit fill level |
| tx_req | output | 1 | Transmit burst request |
| tx_err | output | 1 | Sticky transmit overflow/underflow flag |
| eng_rx_push | input | 1 | Engine writes a received word |
| eng_rx_wdata | input | WIDTH | Received word |
| dma_rx_pop | input | 1 | DMA takes the oldest receive word |
| dma_rx_rdata | output | WIDTH | Oldest receive word |
| rx_level | output | LW | Receive fill level |
| rx_req | output | 1 | Receive burst request |
| rx_err | output | 1 | Sticky receive overflow/underflow flag |

## Verification
A FIFO can accept a write and a read in the same cycle. This is the case in which the level logic and the read pointer most easily disagree. The bench provokes it on the receive FIFO while it holds three words, by asserting the engine write and the DMA read together. It then checks three things: the level still reads three, the word taken is the oldest one held, and the new word comes out later in its proper turn. Burst completion and request re-evaluation meet on consecutive edges. The bench checks the one-cycle low gap and the renewed request at each watermark boundary.

// File: rtl/wm_dma_fifos.sv
module wm_dma_fifos #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    cfg_tx_wm,
  input  logic [LW-1:0]    cfg_rx_wm,
  input  logic [LW-1:0]    cfg_burst,
  input  logic             dma_tx_push,
  input  logic [WIDTH-1:0] dma_tx_wdata,
  input  logic             eng_tx_pop,
  output logic [WIDTH-1:0] eng_tx_rdata,
  output logic [LW-1:0]    tx_level,
  output logic             tx_req,
  output logic             tx_err,
  input  logic             eng_rx_push,
  input  logic [WIDTH-1:0] eng_rx_wdata,
  input  logic             dma_rx_pop,
  output logic [WIDTH-1:0] dma_rx_rdata,
  output logic [LW-1:0]    rx_level,
  output logic             rx_req,
  output logic             rx_err
);

  logic [WIDTH-1:0] tx_mem [DEPTH];
  logic [WIDTH-1:0] rx_mem [DEPTH];
  logic [AW-1:0]    tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0]    tx_cnt, rx_cnt;

  wire [LW-1:0] bsz_m1 = (cfg_burst == '0) ? '0 : cfg_burst - LW'(1);

  wire tx_full  = tx_level == LW'(DEPTH);
  wire tx_empty = tx_level == '0;
  wire tx_wr    = dma_tx_push && !tx_full;
  wire tx_rd    = eng_tx_pop && !tx_empty;

  wire rx_full  = rx_level == LW'(DEPTH);
  wire rx_empty = rx_level == '0;
  wire rx_wr    = eng_rx_push && !rx_full;
  wire rx_rd    = dma_rx_pop && !rx_empty;

  wire tx_hit = tx_level <= cfg_tx_wm;
  wire rx_hit = {1'b0, rx_level} >= ({1'b0, cfg_rx_wm} + (LW+1)'(1));

  assign eng_tx_rdata = tx_mem[tx_rp];
  assign dma_rx_rdata = rx_mem[rx_rp];

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= dma_tx_wdata;
    if (rx_wr) rx_mem[rx_wp] <= eng_rx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp    <= '0;
      tx_rp    <= '0;
      tx_level <= '0;
      tx_err   <= 1'b0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + AW'(1);
      if (tx_rd) tx_rp <= tx_rp + AW'(1);
      tx_level <= tx_level + LW'(tx_wr) - LW'(tx_rd);
      tx_err   <= tx_err | (dma_tx_push && tx_full) | (eng_tx_pop && tx_empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp    <= '0;
      rx_rp    <= '0;
      rx_level <= '0;
      rx_err   <= 1'b0;
    end else begin
      if (rx_wr) rx_wp <= rx_wp + AW'(1);
      if (rx_rd) rx_rp <= rx_rp + AW'(1);
      rx_level <= rx_level + LW'(rx_wr) - LW'(rx_rd);
      rx_err   <= rx_err | (eng_rx_push && rx_full) | (dma_rx_pop && rx_empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req <= 1'b0;
      tx_cnt <= '0;
    end else if (!tx_req) begin
      tx_req <= tx_hit;
      tx_cnt <= '0;
    end else if (tx_wr) begin
      if (tx_cnt == bsz_m1) begin
        tx_req <= 1'b0;
        tx_cnt <= '0;
      end else begin
        tx_cnt <= tx_cnt + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_req <= 1'b0;
      rx_cnt <= '0;
    end else if (!rx_req) begin
      rx_req <= rx_hit;
      rx_cnt <= '0;
    end else if (rx_rd) begin
      if (rx_cnt == bsz_m1) begin
        rx_req <= 1'b0;
        rx_cnt <= '0;
      end else begin
        rx_cnt <= rx_cnt + LW'(1);
      end
    end
  end

endmodule

// File: rtl/wm_dma_fifos_chk.sv
module wm_dma_fifos_chk #(
  parameter int DEPTH = 32,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] cfg_tx_wm,
  input logic [LW-1:0] cfg_rx_wm,
  input logic          dma_tx_push,
  input logic          eng_tx_pop,
  input logic          eng_rx_push,
  input logic          dma_rx_pop,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_req,
  input logic          rx_req,
  input logic          tx_err,
  input logic          rx_err
);

  // R4
  tx_level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH));

  // R4
  rx_level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH));

  // R8
  tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |=> tx_err);

  // R8
  rx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |=> rx_err);

  // R8
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LW'(DEPTH) && dma_tx_push && !eng_tx_pop) |=> (tx_err && tx_level == LW'(DEPTH)));

  // R8
  rx_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && dma_rx_pop && !eng_rx_push) |=> (rx_err && rx_level == '0));

  // R5
  tx_req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_req && tx_level <= cfg_tx_wm) |=> tx_req);

  // R9
  rx_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_req && rx_level <= cfg_rx_wm) |=> !rx_req);

  // R6
  tx_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !dma_tx_push) |=> tx_req);

  // R6
  rx_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !dma_rx_pop) |=> rx_req);

endmodule

bind wm_dma_fifos wm_dma_fifos_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tx_wm(cfg_tx_wm), .cfg_rx_wm(cfg_rx_wm),
  .dma_tx_push(dma_tx_push), .eng_tx_pop(eng_tx_pop),
  .eng_rx_push(eng_rx_push), .dma_rx_pop(dma_rx_pop),
  .tx_level(tx_level), .rx_level(rx_level), .tx_req(tx_req), .rx_req(rx_req),
  .tx_err(tx_err), .rx_err(rx_err)
);

// File: tb/tb_wm_dma_fifos.sv
module tb_wm_dma_fifos;
  localparam int DEPTH = 32;
  localparam int WIDTH = 32;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LW-1:0] cfg_tx_wm = LW'(24), cfg_rx_wm = LW'(7), cfg_burst = LW'(8);
  logic dma_tx_push = 0, eng_tx_pop = 0, eng_rx_push = 0, dma_rx_pop = 0;
  logic [WIDTH-1:0] dma_tx_wdata = '0, eng_rx_wdata = '0;
  logic [WIDTH-1:0] eng_tx_rdata, dma_rx_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_req, rx_req, tx_err, rx_err;

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] txq[$], rxq[$];
  logic tx_mon = 0, rx_mon = 0;
  int seed = 1;

  always #10 clk = ~clk;

  wm_dma_fifos #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [WIDTH-1:0] nextval();
    seed = seed * 1103515245 + 12345;
    return WIDTH'(seed);
  endfunction

  task automatic tx_push(input bit expect_ok);
    dma_tx_push = 1;
    dma_tx_wdata = nextval();
    if (expect_ok) txq.push_back(dma_tx_wdata);
    step();
    dma_tx_push = 0;
  endtask

  task automatic tx_pop();
    eng_tx_pop = 1;
    tx_mon = 1;
    step();
    eng_tx_pop = 0;
    tx_mon = 0;
  endtask

  task automatic rx_push();
    eng_rx_push = 1;
    eng_rx_wdata = nextval();
    rxq.push_back(eng_rx_wdata);
    step();
    eng_rx_push = 0;
  endtask

  task automatic rx_pop(input bit expect_ok);
    dma_rx_pop = 1;
    rx_mon = expect_ok;
    step();
    dma_rx_pop = 0;
    rx_mon = 0;
  endtask

  always @(negedge clk) begin
    if (tx_mon) begin
      logic [WIDTH-1:0] e;
      e = txq.pop_front();
      chk(eng_tx_rdata == e, "R2 tx order", eng_tx_rdata, e);
    end
    if (rx_mon) begin
      logic [WIDTH-1:0] e;
      e = rxq.pop_front();
      chk(dma_rx_rdata == e, "R3 rx order", dma_rx_rdata, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk(tx_level == 0 && rx_level == 0, "R1 levels", tx_level, 0);
    chk(!tx_req && !rx_req && !tx_err && !rx_err, "R1 req/err", {tx_req, rx_req, tx_err, rx_err}, 0);
    rst_n = 1;
    step();
    chk(tx_req == 1, "R5 tx req at level 0", tx_req, 1);
    chk(rx_req == 0, "R9 rx req empty", rx_req, 0);

    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i++) begin
        tx_push(1);
        if (b == 0 && i == 0) chk(tx_req == 1, "R6 tx req held mid burst", tx_req, 1);
        if (b == 2 && i == 0) chk(tx_req == 1 && tx_level == 17, "R6 tx req held", tx_level, 17);
      end
      chk(tx_req == 0, "R7 tx req drops at burst end", tx_req, 0);
      chk(tx_level == LW'(8 * (b + 1)), "R4 tx level", tx_level, 8 * (b + 1));
      step();
      chk(tx_req == (b < 3), "R7 tx req re-evaluated", tx_req, b < 3);
    end

    tx_push(0);
    chk(tx_level == 32, "R8 overflow ignored", tx_level, 32);
    chk(tx_err == 1, "R8 tx err set", tx_err, 1);

    for (int i = 0; i < 7; i++) tx_pop();
    step();
    chk(tx_req == 0 && tx_level == 25, "R5 no tx req above watermark", tx_req, 0);
    tx_pop();
    chk(tx_level == 24, "R4 tx level after pops", tx_level, 24);
    step();
    chk(tx_req == 1, "R5 tx req at watermark", tx_req, 1);
    for (int i = 0; i < 24; i++) tx_pop();
    chk(tx_req == 1 && tx_level == 0, "R6 tx req held while draining", tx_req, 1);
    chk(txq.size() == 0, "R2 tx queue drained", txq.size(), 0);

    for (int i = 0; i < 7; i++) rx_push();
    step();
    chk(rx_req == 0 && rx_level == 7, "R9 no rx req at watermark", rx_req, 0);
    rx_push();
    chk(rx_level == 8, "R4 rx level", rx_level, 8);
    step();
    chk(rx_req == 1, "R9 rx req at watermark plus one", rx_req, 1);
    for (int i = 0; i < 4; i++) rx_pop(1);
    chk(rx_req == 1 && rx_level == 4, "R6 rx req held", rx_level, 4);
    for (int i = 0; i < 4; i++) rx_pop(1);
    chk(rx_req == 0 && rx_level == 0, "R7 rx req drops at burst end", rx_req, 0);
    step();
    chk(rx_req == 0 && rx_err == 0, "R7 rx re-evaluated low", rx_req, 0);
    rx_pop(0);
    chk(rx_err == 1 && rx_level == 0, "R8 rx underflow ignored", rx_level, 0);
    chk(tx_err == 1, "R8 tx err sticky", tx_err, 1);

    for (int i = 0; i < 3; i++) rx_push();
    eng_rx_push = 1;
    eng_rx_wdata = nextval();
    rxq.push_back(eng_rx_wdata);
    dma_rx_pop = 1;
    rx_mon = 1;
    step();
    eng_rx_push = 0;
    dma_rx_pop = 0;
    rx_mon = 0;
    chk(rx_level == 3, "R4 push and pop same cycle", rx_level, 3);
    for (int i = 0; i < 3; i++) rx_pop(1);
    chk(rxq.size() == 0 && rx_level == 0, "R3 rx queue drained", rxq.size(), 0);
    chk(rx_err == 1, "R8 rx err sticky", rx_err, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule